// File: doc/BRIEF.md
# Serial Register Control Interface

This block is the control port of a mixed-signal converter. An external host frames each transfer with an active-low chip select and clocks in sixteen bits on a serial clock. The block turns each accepted write into a one-cycle strobe with address and data, and stores the byte in a small bank of 8-bit configuration registers. The bank contents are presented to the rest of the chip as one flat vector.

In the default mode the port has four wires and can read a register back on a separate data output, which is enabled only while read data is being shifted out. A mode bit held inside the register bank switches the port to a three-wire, write-only mode. All serial pins are sampled with the system clock through synchronizers, so the serial clock has to be several times slower than the system clock. A power-down input returns the bank to its defaults. Writes are refused while power-down is active or while an external detector reports that the converter master clock is missing.

Top module: `serial_reg_ctl`

## Requirements
- R1: A frame is 16 bits, most significant first: chip id in bits 15:14, direction in bit 13 (1 = write, 0 = read), register address in bits 12:8 and data in bits 7:0. An accepted write stores the data byte in the addressed register and pulses `wr_stb` for one system clock, with `wr_addr` and `wr_data` valid.
- R2: A frame whose chip id is not 2'b01 changes no register and never enables `sdo`.
- R3: In four-wire mode (register 2 bit 2 = 0), a read frame drives the addressed register on `sdo`, MSB first. Each bit changes after a falling serial-clock edge, starting after the 8th rising edge, so the host samples all 8 bits on rising edges 9 to 16.
- R4: In three-wire mode (register 2 bit 2 = 1), read frames are ignored and `sdo_oe` stays low, while write frames are still accepted.
- R5: `sdo_oe` is low outside a read frame and goes low again within a few system clocks of chip select rising.
- R6: A write commits only on the 16th rising serial-clock edge after chip select falls. A frame cut short by chip select rising commits nothing. Serial-clock edges after the 16th are ignored, so a frame makes at most one write.
- R7: While `pd_n` is low, all registers return to their defaults and no write is accepted.
- R8: While `mclk_ok` is low, no write is accepted.
- R9: Only addresses 0x00 to 0x09 are implemented. Writes to 0x0A to 0x1F change nothing and raise no strobe, and reads of them return 0x00.
- R10: After reset, the registers hold 0x8C, 0x5B, 0x00, 0x81, 0x04, then 0x00 for addresses 5 to 9. Register n occupies bits 8n+7:8n of `regs`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to sample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_n | input | 1 | Active-low power-down; low restores the register defaults |
| mclk_ok | input | 1 | High when the external detector sees the master clock |
| csn | input | 1 | Active-low chip select that frames each transfer |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| wr_stb | output | 1 | One-cycle pulse on each committed write |
| wr_addr | output | 5 | Register address of the committed write |
| wr_data | output | 8 | Data byte of the committed write |
| regs | output | 80 | Register bank contents, register n at bits 8n+7:8n |

## Verification
The bench sends frames of exactly 16 clocks, short frames cut off after 10 clocks, and long frames of 20 clocks. A design that counts edges wrongly would commit a truncated frame or write twice, and the strobe count would show it. Frames with a foreign chip id, writes to unimplemented addresses, and writes with power-down asserted or the master clock missing all have to leave the bank unchanged. A wrong gate or a missing decode check shows up in the register vector. Read-back is checked bit by bit in both modes: once the mode bit is set, a design that kept reading would enable the output. A design that drove `sdo` one edge early or late would return a shifted byte.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int ID_W       = 2;
    localparam int FRAME_BITS = ID_W + 1 + ADDR_W + DATA_W;
    localparam int HDR_BITS   = ID_W + 1 + ADDR_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [ID_W-1:0] CHIP_ID = 2'b01;

    // location of the wire-mode bit in the bank
    localparam int MODE_REG = 2;
    localparam int MODE_BIT = 2;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h8C;
            1:       return 8'h5B;
            3:       return 8'h81;
            4:       return 8'h04;
            default: return 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic                  sclk_p;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] shreg;
        logic                  rd_act;
        logic [DATA_W-1:0]     rd_sh;
        logic                  sdo;
        logic                  oe;
        logic                  wr_stb;
        logic [ADDR_W-1:0]     wr_addr;
        logic [DATA_W-1:0]     wr_data;
    } eng_state_t;

endpackage

// File: rtl/serial_pin_sync.sv
module serial_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
    import serial_reg_pkg::*;
#(
    parameter int NUM_IMPL = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              pd_n,
    input  logic              mclk_ok,
    input  logic              three_wire,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0]  CNT_HDR  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0]  CNT_DRV  = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(FRAME_BITS);
    localparam logic [ADDR_W:0]   ADDR_LIM = (ADDR_W+1)'(NUM_IMPL);

    eng_state_t st_d, st_q;
    logic       rise, fall;
    logic [FRAME_BITS-1:0] shift_nx;
    logic [ID_W-1:0]   f_id, h_id;
    logic              f_wr, h_wr;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;

    always_comb begin
        shift_nx = {st_q.shreg[FRAME_BITS-2:0], sdi_s};
        h_id     = shift_nx[HDR_BITS-1 -: ID_W];
        h_wr     = shift_nx[ADDR_W];
        f_id     = shift_nx[FRAME_BITS-1 -: ID_W];
        f_wr     = shift_nx[FRAME_BITS-1-ID_W];
        f_addr   = shift_nx[DATA_W +: ADDR_W];
        f_data   = shift_nx[DATA_W-1:0];
        rd_addr  = shift_nx[ADDR_W-1:0];
        rise     = !csn_s && sclk_s && !st_q.sclk_p;
        fall     = !csn_s && !sclk_s && st_q.sclk_p;

        st_d        = st_q;
        st_d.sclk_p = sclk_s;
        st_d.wr_stb = 1'b0;

        if (csn_s) begin
            st_d.cnt    = '0;
            st_d.rd_act = 1'b0;
            st_d.oe     = 1'b0;
            st_d.sdo    = 1'b0;
        end else begin
            if (rise && st_q.cnt < CNT_END) begin
                st_d.shreg = shift_nx;
                st_d.cnt   = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_HDR && h_id == CHIP_ID && !h_wr && !three_wire) begin
                    st_d.rd_act = 1'b1;
                    st_d.rd_sh  = rd_data;
                end
                if (st_q.cnt == CNT_LAST && f_id == CHIP_ID && f_wr &&
                    pd_n && mclk_ok && {1'b0, f_addr} < ADDR_LIM) begin
                    st_d.wr_stb  = 1'b1;
                    st_d.wr_addr = f_addr;
                    st_d.wr_data = f_data;
                end
            end
            if (fall && st_q.rd_act && st_q.cnt >= CNT_DRV && st_q.cnt < CNT_END) begin
                st_d.sdo   = st_q.rd_sh[DATA_W-1];
                st_d.rd_sh = {st_q.rd_sh[DATA_W-2:0], 1'b0};
                st_d.oe    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo     = st_q.sdo;
    assign sdo_oe  = st_q.oe;
    assign wr_stb  = st_q.wr_stb;
    assign wr_addr = st_q.wr_addr;
    assign wr_data = st_q.wr_data;

endmodule

// File: rtl/serial_reg_bank.sv
module serial_reg_bank
    import serial_reg_pkg::*;
#(
    parameter int NUM_IMPL = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pd_n,
    input  logic                       wr_stb,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       three_wire,
    output logic [NUM_IMPL*DATA_W-1:0] regs_flat
);

    logic [DATA_W-1:0] bank_d [NUM_IMPL];
    logic [DATA_W-1:0] bank_q [NUM_IMPL];

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_IMPL; i++) begin
            bank_d[i] = bank_q[i];
            if (!pd_n) begin
                bank_d[i] = reg_default(i);
            end else if (wr_stb && wr_addr == ADDR_W'(i)) begin
                bank_d[i] = wr_data;
            end
            if (rd_addr == ADDR_W'(i)) rd_data = bank_q[i];
        end
    end

    generate
        for (genvar g = 0; g < NUM_IMPL; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) bank_q[g] <= reg_default(g);
                else        bank_q[g] <= bank_d[g];
            end
            assign regs_flat[g*DATA_W +: DATA_W] = bank_q[g];
        end
    endgenerate

    assign three_wire = bank_q[MODE_REG][MODE_BIT];

endmodule

// File: rtl/serial_reg_ctl.sv
module serial_reg_ctl
    import serial_reg_pkg::*;
#(
    parameter int NUM_IMPL = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pd_n,
    input  logic                       mclk_ok,
    input  logic                       csn,
    input  logic                       sclk,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic                       wr_stb,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data,
    output logic [NUM_IMPL*DATA_W-1:0] regs
);

    logic [2:0]        pins_s;
    logic              csn_s, sclk_s, sdi_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              three_wire;

    serial_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({csn, sclk, sdi}),
        .dout (pins_s)
    );

    assign csn_s  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    serial_frame_engine #(.NUM_IMPL(NUM_IMPL)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_s     (csn_s),
        .sclk_s    (sclk_s),
        .sdi_s     (sdi_s),
        .pd_n      (pd_n),
        .mclk_ok   (mclk_ok),
        .three_wire(three_wire),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    serial_reg_bank #(.NUM_IMPL(NUM_IMPL)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .three_wire(three_wire),
        .regs_flat (regs)
    );

endmodule

// File: rtl/serial_reg_ctl_chk.sv
module serial_reg_ctl_chk
    import serial_reg_pkg::*;
#(
    parameter int NUM_IMPL = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pd_n,
    input logic                       mclk_ok,
    input logic                       csn_s,
    input logic                       sdo_oe,
    input logic                       wr_stb,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [NUM_IMPL*DATA_W-1:0] regs
);

    logic [NUM_IMPL*DATA_W-1:0] defaults;
    always_comb begin
        for (int i = 0; i < NUM_IMPL; i++) defaults[i*DATA_W +: DATA_W] = reg_default(i);
    end

    AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !sdo_oe); // R5

    AST_WR_PD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(pd_n)); // R7

    AST_WR_MCLK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(mclk_ok)); // R8

    AST_WR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (int'(wr_addr) < NUM_IMPL)); // R9

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R6

    AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(csn_s)); // R6

    AST_PD_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (regs == defaults)); // R7

endmodule

bind serial_reg_ctl serial_reg_ctl_chk #(.NUM_IMPL(NUM_IMPL)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pd_n   (pd_n),
    .mclk_ok(mclk_ok),
    .csn_s  (csn_s),
    .sdo_oe (sdo_oe),
    .wr_stb (wr_stb),
    .wr_addr(wr_addr),
    .regs   (regs)
);

// File: tb/serial_reg_ctl_bench.sv
module serial_reg_ctl_bench;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b1;
    logic        mclk_ok = 1'b1;
    logic        csn = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe, wr_stb;
    logic [4:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [79:0] regs;

    int n_chk = 0;
    int n_err = 0;
    int n_stb = 0;

    logic [7:0] model [10];

    int         q_bits [$];
    logic [7:0] q_dat  [$];
    string      q_req  [$];

    int         cap_n = 0;
    logic [7:0] cap   = '0;

    always #10 clk = ~clk;

    serial_reg_ctl u_serial_reg_ctl (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .mclk_ok(mclk_ok),
        .csn(csn), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .regs(regs)
    );

    always @(posedge clk) if (rst_n && wr_stb) n_stb++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [79:0] model_flat();
        logic [79:0] f;
        for (int i = 0; i < 10; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 10; i++) model[i] = 8'h00;
        model[0] = 8'h8C; model[1] = 8'h5B; model[3] = 8'h81; model[4] = 8'h04;
    endtask

    // monitor: capture driven read bits, compare on chip-select release
    always @(posedge sclk) begin
        if (!csn && sdo_oe) begin
            cap = {cap[6:0], sdo};
            cap_n++;
        end
    end

    always @(posedge csn) begin
        if (q_bits.size() == 0) begin
            check(1'b0, "R3", "unexpected frame", 80'(cap_n), 80'(0));
        end else begin
            automatic int         eb = q_bits.pop_front();
            automatic logic [7:0] ed = q_dat.pop_front();
            automatic string      er = q_req.pop_front();
            check(cap_n == eb, er, "driven bit count", 80'(cap_n), 80'(eb));
            if (eb == 8) check(cap == ed, er, "read data", 80'(cap), 80'(ed));
        end
        cap_n = 0;
        cap   = '0;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [1:0] id, input logic wr, input logic [4:0] addr,
                         input logic [7:0] data, input int nclk,
                         input int exp_bits, input logic [7:0] exp_rd, input string req);
        logic [15:0] w;
        w = {id, wr, addr, data};
        q_bits.push_back(exp_bits);
        q_dat.push_back(exp_rd);
        q_req.push_back(req);
        csn = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < nclk; b++) begin
            sdi = (b < 16) ? w[15-b] : 1'b0;
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(12);
        check(sdo_oe == 1'b0, "R5", "oe after chip select high", 80'(sdo_oe), 80'(0));
    endtask

    task automatic check_regs(input string req, input string what);
        check(regs == model_flat(), req, what, regs, model_flat());
    endtask

    initial begin
        int s0;
        model_reset();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        check_regs("R10", "defaults after reset");
        check(sdo_oe == 1'b0, "R5", "oe idle after reset", 80'(sdo_oe), 80'(0));

        // R1: plain write
        s0 = n_stb;
        frame(2'b01, 1'b1, 5'd5, 8'hA5, 16, 0, 8'h00, "R1");
        model[5] = 8'hA5;
        check_regs("R1", "write addr 5");
        check(n_stb == s0 + 1, "R1", "one strobe", 80'(n_stb - s0), 80'(1));
        frame(2'b01, 1'b1, 5'd9, 8'h3C, 16, 0, 8'h00, "R1");
        model[9] = 8'h3C;
        check_regs("R1", "write addr 9");

        // R3: reads in four-wire mode
        frame(2'b01, 1'b0, 5'd5, 8'h00, 16, 8, 8'hA5, "R3");
        frame(2'b01, 1'b0, 5'd4, 8'hFF, 16, 8, 8'h04, "R3");
        frame(2'b01, 1'b0, 5'd1, 8'h00, 16, 8, 8'h5B, "R3");

        // R2: foreign chip ids
        frame(2'b10, 1'b1, 5'd6, 8'h77, 16, 0, 8'h00, "R2");
        frame(2'b00, 1'b1, 5'd6, 8'h77, 16, 0, 8'h00, "R2");
        check_regs("R2", "foreign id write ignored");
        frame(2'b11, 1'b0, 5'd5, 8'h00, 16, 0, 8'h00, "R2");

        // R9: unimplemented addresses
        s0 = n_stb;
        frame(2'b01, 1'b1, 5'h0C, 8'hEE, 16, 0, 8'h00, "R9");
        frame(2'b01, 1'b1, 5'h1F, 8'hEE, 16, 0, 8'h00, "R9");
        check_regs("R9", "high address write ignored");
        check(n_stb == s0, "R9", "no strobe", 80'(n_stb - s0), 80'(0));
        frame(2'b01, 1'b0, 5'h0A, 8'h00, 16, 8, 8'h00, "R9");

        // R6: truncated and overlong frames
        s0 = n_stb;
        frame(2'b01, 1'b1, 5'd7, 8'h5A, 10, 0, 8'h00, "R6");
        frame(2'b01, 1'b1, 5'd7, 8'h5A, 15, 0, 8'h00, "R6");
        check_regs("R6", "short frame commits nothing");
        check(n_stb == s0, "R6", "no strobe on short frame", 80'(n_stb - s0), 80'(0));
        frame(2'b01, 1'b1, 5'd7, 8'hC3, 20, 0, 8'h00, "R6");
        model[7] = 8'hC3;
        check_regs("R6", "long frame writes once");
        check(n_stb == s0 + 1, "R6", "single strobe on long frame", 80'(n_stb - s0), 80'(1));

        // R8: master clock missing
        mclk_ok = 1'b0;
        frame(2'b01, 1'b1, 5'd6, 8'h99, 16, 0, 8'h00, "R8");
        check_regs("R8", "write blocked without master clock");
        mclk_ok = 1'b1;
        frame(2'b01, 1'b1, 5'd6, 8'h99, 16, 0, 8'h00, "R8");
        model[6] = 8'h99;
        check_regs("R8", "write accepted after clock returns");

        // R7: power-down
        pd_n = 1'b0;
        wait_clk(3);
        model_reset();
        check_regs("R7", "defaults during power-down");
        frame(2'b01, 1'b1, 5'd5, 8'h11, 16, 0, 8'h00, "R7");
        check_regs("R7", "write blocked in power-down");
        pd_n = 1'b1;
        wait_clk(3);
        check_regs("R7", "defaults after power-up");

        // R4: three-wire mode
        frame(2'b01, 1'b1, 5'd2, 8'h04, 16, 0, 8'h00, "R4");
        model[2] = 8'h04;
        check_regs("R4", "mode bit set");
        frame(2'b01, 1'b0, 5'd0, 8'h00, 16, 0, 8'h00, "R4");
        frame(2'b01, 1'b1, 5'd8, 8'h6E, 16, 0, 8'h00, "R4");
        model[8] = 8'h6E;
        check_regs("R4", "write in three-wire mode");
        frame(2'b01, 1'b1, 5'd2, 8'h00, 16, 0, 8'h00, "R4");
        model[2] = 8'h00;
        frame(2'b01, 1'b0, 5'd8, 8'h00, 16, 8, 8'h6E, "R3");

        check(q_bits.size() == 0, "R3", "scoreboard drained", 80'(q_bits.size()), 80'(0));
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog expired: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule